// File: doc/BRIEF.md
# Strap-Selected Audio Frame and Bit Clock Generator

This block runs the audio serial port as clock controller. It divides its system clock into a bit clock with a 50% duty cycle and a frame sync that is high for one bit period. Two strap inputs and a slot-format input choose the frame rate and the number of bit clocks per frame. The frame rate is either the system clock divided by 256 or by 128, or it is a fixed rate from the 48 kHz or 44.1 kHz family. The `SYS_HZ` parameter gives the system clock frequency, and the family is chosen from it.

In TDM format with a divided rate, the bit clocks per frame depend on the resulting frame rate. In I2S format with a divided rate, every frame has 64 bit clocks, which is two 32-bit slots. The fixed rates use 128 bit clocks per frame at the double rate and 256 at the base rate. The bit-clock divider equals `SYS_HZ / (frame rate × ratio)`. The setting is invalid when this divider is not an integer, is odd, or is below 2. In that case the block raises an error flag and holds both clocks low.

Top module: `audio_clkgen`

## Requirements
- R1: With strap_hi=0 and strap_lo=0, a frame lasts 256 system clock cycles.
- R2: With strap_hi=0 and strap_lo=1, a frame lasts 128 system clock cycles.
- R3: With strap_hi=1, the frame rate is fixed. strap_lo=0 selects 2×base with 128 bit clocks per frame. strap_lo=1 selects base with 256 bit clocks per frame. base is 48000 Hz when SYS_HZ is a multiple of 48000, and 44100 Hz otherwise.
- R4: With strap_hi=0 and tdm_en=0, every frame has 64 bit clocks.
- R5: With strap_hi=0 and tdm_en=1, the bit clocks per frame depend on the frame rate fs. The count is 256 when fs ≤ 48 kHz, 128 when 48 kHz < fs ≤ 96 kHz, and 64 when fs > 96 kHz.
- R6: ratio_code reports the bit clocks per frame of the active setting: 0 means 64, 1 means 128 and 2 means 256. The value 3 never appears.
- R7: While a valid setting runs, bclk is low for D/2 system clock cycles and then high for D/2, where D is the divider. A frame starts on a falling bclk edge.
- R8: fsync rises on the falling bclk edge that starts a frame and falls on the next falling bclk edge.
- R9: While a valid setting runs, a change of the straps or of tdm_en takes effect only at the next frame start. The new setting is sampled at that edge.
- R10: When the active setting is invalid, cfg_err is high and bclk and fsync are low. The inputs are then sampled on every clock until a valid setting is found.
- R11: During reset, bclk, fsync and cfg_err are low. The first setting is sampled on the first clock after reset. The first frame starts one bit period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_hi | input | 1 | Strap: selects a divided rate (0) or a fixed rate (1) |
| strap_lo | input | 1 | Strap: selects the divisor or the fixed rate |
| tdm_en | input | 1 | Slot format: 0 selects I2S, 1 selects TDM |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync, one bit period wide |
| ratio_code | output | 2 | Bit clocks per frame of the active setting |
| cfg_err | output | 1 | Active setting is invalid |

## Verification
Every output is a register. A change caused by a clock edge is therefore visible right after that edge. The straps are read at the load edge itself: the first edge after reset, every edge while in error, and each frame-start edge. The new setting shows at the outputs right after that edge. The bench keeps a model that counts each instance's position in its frame edge by edge, applies new inputs on the same edges as the design, and compares all four outputs half a period after every edge. It also measures the distance between fsync rises against the frame length expected for each setting.

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter longint unsigned SYS_HZ = 24_576_000,
  parameter int CW = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_hi,
  input  logic       strap_lo,
  input  logic       tdm_en,
  output logic       bclk,
  output logic       fsync,
  output logic [1:0] ratio_code,
  output logic       cfg_err
);
  localparam int BW = 9;
  localparam longint unsigned BASE = (SYS_HZ % 48000 == 0) ? 48000 : 44100;

  function automatic longint unsigned ratio_f(input int idx);
    longint unsigned n;
    n = idx[1] ? 128 : 256;
    if (idx[2]) return idx[1] ? 256 : 128;
    if (!idx[0]) return 64;
    if (SYS_HZ <= 48000 * n) return 256;
    if (SYS_HZ <= 96000 * n) return 128;
    return 64;
  endfunction

  function automatic longint unsigned per_frame_f(input int idx);
    longint unsigned fsx;
    fsx = idx[1] ? BASE : 2 * BASE;
    return idx[2] ? SYS_HZ / fsx : (idx[1] ? 128 : 256);
  endfunction

  function automatic bit exact_f(input int idx);
    longint unsigned fsx;
    fsx = idx[1] ? BASE : 2 * BASE;
    if (idx[2]) return (SYS_HZ % (fsx * ratio_f(idx))) == 0;
    return ((idx[1] ? 128 : 256) % ratio_f(idx)) == 0;
  endfunction

  function automatic bit bad_f(input int idx);
    longint unsigned d;
    d = per_frame_f(idx) / ratio_f(idx);
    return !exact_f(idx) || d < 2 || d[0] || (d / 2) > ((64'd1 << CW) - 1);
  endfunction

  logic [CW-1:0] half_tab  [8];
  logic [BW-1:0] rlast_tab [8];
  logic [1:0]    code_tab  [8];
  logic          err_tab   [8];

  for (genvar g = 0; g < 8; g++) begin : g_cfg
    localparam longint unsigned RAT = ratio_f(g);
    localparam longint unsigned DIV = per_frame_f(g) / RAT;
    localparam bit BAD = bad_f(g);
    assign half_tab[g]  = BAD ? '0 : CW'(DIV / 2);
    assign rlast_tab[g] = BW'(RAT - 1);
    assign code_tab[g]  = (RAT == 64) ? 2'd0 : (RAT == 128) ? 2'd1 : 2'd2;
    assign err_tab[g]   = BAD;
  end

  logic          armed, bclk_r, fsync_r;
  logic [2:0]    cfg;
  logic [CW-1:0] hcnt;
  logic [BW-1:0] bitcnt;
  wire  [2:0]    sel = {strap_hi, strap_lo, tdm_en};
  wire           run = armed & ~err_tab[cfg];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; cfg <= '0; hcnt <= '0; bitcnt <= '0;
      bclk_r <= 1'b0; fsync_r <= 1'b0;
    end else if (!run) begin
      armed <= 1'b1; cfg <= sel; hcnt <= '0; bitcnt <= '0;
      bclk_r <= 1'b0; fsync_r <= 1'b0;
    end else if (hcnt == half_tab[cfg] - 1'b1) begin
      hcnt   <= '0;
      bclk_r <= ~bclk_r;
      if (bclk_r) begin
        if (bitcnt == '0) begin
          cfg     <= sel;
          bitcnt  <= rlast_tab[sel];
          fsync_r <= 1'b1;
        end else begin
          bitcnt  <= bitcnt - 1'b1;
          fsync_r <= 1'b0;
        end
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign bclk       = bclk_r & run;
  assign fsync      = fsync_r & run;
  assign cfg_err    = armed & err_tab[cfg];
  assign ratio_code = code_tab[cfg];

  // R8
  fsync_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> $fell(bclk));
  // R8
  fsync_drop_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync) |-> $fell(bclk));
  // R9
  cfg_hold_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) && !$rose(fsync_r) |-> $stable(cfg));
  // R6
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_code != 2'd3);
  // R10
  err_quiet_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !$rose(bclk) && !$rose(fsync));
endmodule

// File: tb/audio_clkgen_test.sv
module audio_clkgen_test;
  localparam int CLK_PERIOD = 10;
  localparam longint SYS_A = 24_576_000;
  localparam longint SYS_B = 12_288_000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_hi = 1'b0, s_lo = 1'b0, tdm = 1'b0;
  logic       bclk_o [2];
  logic       fsync_o[2];
  logic [1:0] code_o [2];
  logic       err_o  [2];
  int checks = 0, failures = 0, cyc = 0;
  string phase_tag = "R11";

  always #(CLK_PERIOD / 2) clk = ~clk;

  audio_clkgen #(.SYS_HZ(SYS_A)) uut (.clk(clk), .rst_n(rst_n), .strap_hi(s_hi),
    .strap_lo(s_lo), .tdm_en(tdm), .bclk(bclk_o[0]), .fsync(fsync_o[0]),
    .ratio_code(code_o[0]), .cfg_err(err_o[0]));
  audio_clkgen #(.SYS_HZ(SYS_B)) uut_lo (.clk(clk), .rst_n(rst_n), .strap_hi(s_hi),
    .strap_lo(s_lo), .tdm_en(tdm), .bclk(bclk_o[1]), .fsync(fsync_o[1]),
    .ratio_code(code_o[1]), .cfg_err(err_o[1]));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Reference: derive ratio and divider from the stated rules with real arithmetic
  task automatic ref_cfg(input int idx, input longint sys, output int ratio,
                         output int div, output bit err);
    real base, fs, d;
    base = (sys % 48000 == 0) ? 48000.0 : 44100.0;
    if (idx[2]) begin
      fs = idx[1] ? base : 2.0 * base;
      ratio = idx[1] ? 256 : 128;
    end else begin
      fs = real'(sys) / (idx[1] ? 128.0 : 256.0);
      ratio = !idx[0] ? 64 : (fs <= 48000.0) ? 256 : (fs <= 96000.0) ? 128 : 64;
    end
    d = real'(sys) / (fs * ratio);
    div = $rtoi(d);
    err = (d < 2.0) || (d != real'(div)) || (div % 2 != 0);
  endtask

  int m_pos[2], m_ratio[2], m_div[2];
  bit m_arm[2], m_err[2];
  longint sys_of[2] = '{SYS_A, SYS_B};

  task automatic m_load(input int k, input bit idle);
    int r, d; bit e;
    ref_cfg({s_hi, s_lo, tdm}, sys_of[k], r, d, e);
    m_arm[k] = 1; m_ratio[k] = r; m_div[k] = d; m_err[k] = e;
    m_pos[k] = idle ? r * d - d : 0;
  endtask

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_arm[k] = 0; m_pos[k] = 0;
        ref_cfg(0, sys_of[k], m_ratio[k], m_div[k], m_err[k]);
      end else if (!m_arm[k] || m_err[k]) m_load(k, 1);
      else begin
        m_pos[k]++;
        if (m_pos[k] == m_ratio[k] * m_div[k]) m_load(k, 0);
      end
    end
  end

  int last_rise = -1, gap = 0;
  logic prev_fs = 1'b0;

  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < 2; k++) begin
      bit run, eb, ef; int ec;
      run = m_arm[k] && !m_err[k];
      eb = run && ((m_pos[k] % m_div[k]) >= m_div[k] / 2);
      ef = run && (m_pos[k] < m_div[k]);
      ec = (m_ratio[k] == 64) ? 0 : (m_ratio[k] == 128) ? 1 : 2;
      check(bclk_o[k] == eb, {"R7 bclk/", phase_tag}, bclk_o[k], eb);
      check(fsync_o[k] == ef, {"R8 fsync/", phase_tag}, fsync_o[k], ef);
      check(code_o[k] == ec, {"R6 code/", phase_tag}, code_o[k], ec);
      check(err_o[k] == (m_arm[k] && m_err[k]), {"R10 err/", phase_tag},
            err_o[k], m_arm[k] && m_err[k]);
    end
    if (fsync_o[0] && !prev_fs) begin
      if (last_rise >= 0) gap = cyc - last_rise;
      last_rise = cyc;
    end
    prev_fs = fsync_o[0];
  end

  function automatic string tag_of(input int idx);
    if (idx[2]) return "R3";
    if (idx[0]) return idx[1] ? "R2 R5" : "R1 R5";
    return idx[1] ? "R2 R4" : "R1 R4";
  endfunction

  task automatic set_in(input int idx);
    @(negedge clk);
    {s_hi, s_lo, tdm} = idx[2:0];
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    check(bclk_o[0] == 0 && fsync_o[0] == 0 && err_o[0] == 0, "R11 reset", bclk_o[0], 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      int r, d; bit e;
      phase_tag = tag_of(i);
      set_in(i);
      repeat (1500) @(negedge clk);
      ref_cfg(i, SYS_A, r, d, e);
      check(gap == r * d, {"frame length ", tag_of(i)}, gap, r * d);
    end
    // R9: inputs bounce inside frames
    phase_tag = "R9";
    for (int j = 0; j < 60; j++) begin
      set_in((j * 5 + 3) % 8);
      repeat (37) @(negedge clk);
    end
    // R10: leave an invalid setting on the low-rate instance, then recover
    phase_tag = "R10";
    set_in(7);
    repeat (600) @(negedge clk);
    check(err_o[1] == 1, "R10 lo err", err_o[1], 1);
    set_in(0);
    repeat (600) @(negedge clk);
    check(err_o[1] == 0, "R10 lo recover", err_o[1], 0);
    // R11: reset in mid-frame and restart
    phase_tag = "R11";
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(bclk_o[0] == 0 && fsync_o[0] == 0, "R11 mid reset", bclk_o[0], 0);
    set_in(3);
    rst_n = 1'b1;
    repeat (800) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule